// File: doc/BRIEF.md
# Phase-Frequency Detector with Windowed Lock Qualifier

This block compares two divided pulse trains, a reference-side pulse and a VCO-side pulse, both generated in the reference-oscillator clock domain. A rising edge on the reference input that arrives before the matching VCO edge raises the pump-up command. A VCO edge that arrives first raises the pump-down command. Once both sides have seen their edge, both commands clear together after a one-cycle overlap. When neither command is active, the charge-pump output is reported as high impedance, so the analog pump driven from these signals floats.

The same logic measures each comparison in reference-oscillator clock cycles. The measurement runs from the first edge to the partner edge. A comparison counts as in-window when the partner edge comes fewer than `WIN_CLKS` cycles after the first edge (default 2). The lock flag rises only after `LOCK_RUNS` in-window comparisons in a row (default 4, which is more than three). As soon as the error reaches the window limit, the run is broken and the flag drops, even if the partner edge has not yet arrived. In stand-by, the pump commands are idle, the output reads high impedance, and the lock flag reads high. A lock-enable bit forces the flag low while stand-by is off.

Top module: `pfd_lockdet`

## Requirements
- R1: A rising edge on `fr_in` sampled at clock edge t, with no comparison pending, sets `up` after edge t. `up` stays high until the partner edge clears it.
- R2: A rising edge on `fv_in` sampled at edge t, with no comparison pending, sets `dn` after edge t. `dn` stays high until the partner edge clears it.
- R3: When the partner edge arrives at edge t, `up` and `dn` are both high after edge t and both low after edge t+1. Edges arriving during that overlap cycle are ignored.
- R4: `cp_hiz` is 1 exactly when neither `up` nor `dn` is high, and always during stand-by.
- R5: The phase error is the number of clock edges between the first edge and its partner, with 0 when both arrive at the same edge. A comparison is in-window when the error is below `WIN_CLKS` (default 2).
- R6: With `ld_en`=1 and stand-by off, `ld` goes high after the edge that completes the fourth (`LOCK_RUNS`) consecutive in-window comparison. It stays low after only three.
- R7: Once a pending comparison reaches `WIN_CLKS` cycles without its partner, the run count is cleared and `ld` is low after that edge. After an out-of-window comparison, `LOCK_RUNS` new in-window comparisons are needed again.
- R8: While `standby`=1, `ld` reads 1, `up` and `dn` read 0 and `cp_hiz` reads 1, with no clock delay. Edges received during stand-by have no effect. Stand-by clears the run count, so `ld` is low after exit until a new run completes.
- R9: With stand-by off and `ld_en`=0, `ld` reads 0. The run count continues underneath, so `ld` reads 1 again as soon as `ld_en` returns to 1 on a locked loop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference-oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| fr_in | input | 1 | Divided reference pulse, synchronous to clk |
| fv_in | input | 1 | Divided VCO pulse, synchronous to clk |
| standby | input | 1 | Stand-by request |
| ld_en | input | 1 | Lock-flag enable; 0 forces the flag low |
| up | output | 1 | Pump-up command (reference leads) |
| dn | output | 1 | Pump-down command (VCO leads) |
| cp_hiz | output | 1 | Charge-pump output floats |
| ld | output | 1 | Lock flag |

## Verification
The assertions assume that both pulse inputs are already synchronous to the reference-oscillator clock, and that each pulse is seen as a single rising edge per period. They also assume that stand-by and lock-enable change only between clock edges. The bench drives every input just after the falling clock edge and keeps each pulse high for one cycle. Each pulse pair sits in a frame with several idle cycles, so every comparison completes before the next one starts. The only exceptions are the scenarios that deliberately leave an edge pending past the window, or that hold a pulse high across cycles.

// File: rtl/pfd_lockdet_pkg.sv
package pfd_lockdet_pkg;

    // Rising-edge strobes of the two compared pulse trains
    typedef struct packed {
        logic fr;
        logic fv;
    } pfd_edges_t;

    // Detector phase, encoded as {up_q, dn_q}
    typedef enum logic [1:0] {
        PH_IDLE     = 2'b00,
        PH_VCO_LEAD = 2'b01,
        PH_REF_LEAD = 2'b10,
        PH_CLEAR    = 2'b11
    } pfd_phase_t;

    function automatic pfd_phase_t phase_of(input logic up_q, input logic dn_q);
        return pfd_phase_t'({up_q, dn_q});
    endfunction

    function automatic logic one_side_pending(input pfd_phase_t ph);
        return (ph == PH_REF_LEAD) || (ph == PH_VCO_LEAD);
    endfunction

endpackage

// File: rtl/pfd_edge_det.sv
module pfd_edge_det #(
    parameter int CHANNELS = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CHANNELS-1:0] sig,
    output logic [CHANNELS-1:0] rise
);
    logic [CHANNELS-1:0] sig_d;

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        always_ff @(posedge clk) begin
            if (rst) sig_d[i] <= 1'b0;
            else     sig_d[i] <= sig[i];
        end
        assign rise[i] = sig[i] & ~sig_d[i];
    end

endmodule

// File: rtl/pfd_core.sv
module pfd_core
    import pfd_lockdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       standby,
    input  pfd_edges_t rise,
    output logic       up_q,
    output logic       dn_q,
    output logic       up,
    output logic       dn,
    output logic       cp_hiz
);
    logic both;
    assign both = up_q & dn_q;

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else if (both) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_q | rise.fr;
            dn_q <= dn_q | rise.fv;
        end
    end

    assign up     = up_q & ~standby;
    assign dn     = dn_q & ~standby;
    assign cp_hiz = standby | ~(up_q | dn_q);

    // R3: the overlap lasts one cycle only
    a_r3_overlap_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (up_q && dn_q) |=> (!up_q && !dn_q));

    // R8: stand-by empties the detector
    a_r8_standby_idle: assert property (@(posedge clk) disable iff (rst)
        standby |=> (!up_q && !dn_q));

endmodule

// File: rtl/pfd_phase_meter.sv
module pfd_phase_meter
    import pfd_lockdet_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int WIN_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby,
    input  pfd_edges_t rise,
    input  logic       up_q,
    input  logic       dn_q,
    output logic       cmp_valid,
    output logic       in_win,
    output logic       over_win
);
    localparam logic [CNT_W-1:0] WIN_V = CNT_W'(WIN_CLKS);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    pfd_phase_t       phase;
    logic             pending;
    logic             first_edge;
    logic             partner_edge;
    logic             same_edge;
    logic [CNT_W-1:0] gap_cnt;
    logic [CNT_W-1:0] err;

    assign phase   = phase_of(up_q, dn_q);
    assign pending = one_side_pending(phase);

    always_comb begin
        first_edge   = 1'b0;
        partner_edge = 1'b0;
        same_edge    = 1'b0;
        case (phase)
            PH_IDLE: begin
                same_edge  = rise.fr & rise.fv;
                first_edge = rise.fr ^ rise.fv;
            end
            PH_REF_LEAD: partner_edge = rise.fv;
            PH_VCO_LEAD: partner_edge = rise.fr;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || standby)                begin gap_cnt <= '0; end
        else if (first_edge)               begin gap_cnt <= CNT_W'(1); end
        else if (pending && !partner_edge) begin
            if (gap_cnt != CNT_MAX) gap_cnt <= gap_cnt + CNT_W'(1);
        end
        else                               begin gap_cnt <= '0; end
    end

    assign err       = same_edge ? '0 : gap_cnt;
    assign cmp_valid = (partner_edge | same_edge) & ~standby;
    assign in_win    = err < WIN_V;
    assign over_win  = pending && (gap_cnt >= WIN_V) && !standby;

    // R7: a comparison pending one cycle short of the window is flagged on the next edge
    a_r7_window_reached: assert property (@(posedge clk) disable iff (rst)
        (pending && !partner_edge && !standby && gap_cnt == WIN_V - CNT_W'(1))
            |=> (gap_cnt >= WIN_V && pending));

endmodule

// File: rtl/pfd_lock_qual.sv
module pfd_lock_qual #(
    parameter int LOCK_RUNS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    input  logic ld_en,
    input  logic cmp_valid,
    input  logic in_win,
    input  logic over_win,
    output logic ld
);
    localparam int LK_W = $clog2(LOCK_RUNS + 1);
    localparam logic [LK_W-1:0] RUNS_V = LK_W'(LOCK_RUNS);

    logic [LK_W-1:0] run_cnt;
    logic            hit;
    logic            miss;
    logic            locked;

    assign hit  = cmp_valid & in_win;
    assign miss = over_win | (cmp_valid & ~in_win);

    always_ff @(posedge clk) begin
        if (rst || standby)              run_cnt <= '0;
        else if (miss)                   run_cnt <= '0;
        else if (hit && run_cnt != RUNS_V) run_cnt <= run_cnt + LK_W'(1);
    end

    assign locked = (run_cnt == RUNS_V);
    assign ld     = standby | (ld_en & locked);

    // R7: a miss leaves the flag's source low
    a_r7_miss_unlocks: assert property (@(posedge clk) disable iff (rst)
        miss |=> !locked);

    // R6: lock is only reached on an in-window comparison
    a_r6_lock_on_hit: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> $past(hit));

endmodule

// File: rtl/pfd_lockdet.sv
module pfd_lockdet
    import pfd_lockdet_pkg::*;
#(
    parameter int CNT_W     = 4,
    parameter int WIN_CLKS  = 2,
    parameter int LOCK_RUNS = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fr_in,
    input  logic fv_in,
    input  logic standby,
    input  logic ld_en,
    output logic up,
    output logic dn,
    output logic cp_hiz,
    output logic ld
);
    logic [1:0] rise_v;
    pfd_edges_t rise;
    logic       up_q;
    logic       dn_q;
    logic       cmp_valid;
    logic       in_win;
    logic       over_win;

    pfd_edge_det #(.CHANNELS(2)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .sig  ({fr_in, fv_in}),
        .rise (rise_v)
    );

    assign rise = pfd_edges_t'(rise_v);

    pfd_core u_core (
        .clk     (clk),
        .rst     (rst),
        .standby (standby),
        .rise    (rise),
        .up_q    (up_q),
        .dn_q    (dn_q),
        .up      (up),
        .dn      (dn),
        .cp_hiz  (cp_hiz)
    );

    pfd_phase_meter #(.CNT_W(CNT_W), .WIN_CLKS(WIN_CLKS)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .rise      (rise),
        .up_q      (up_q),
        .dn_q      (dn_q),
        .cmp_valid (cmp_valid),
        .in_win    (in_win),
        .over_win  (over_win)
    );

    pfd_lock_qual #(.LOCK_RUNS(LOCK_RUNS)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .standby   (standby),
        .ld_en     (ld_en),
        .cmp_valid (cmp_valid),
        .in_win    (in_win),
        .over_win  (over_win),
        .ld        (ld)
    );

endmodule

// File: tb/pfd_lockdet_bench.sv
module pfd_lockdet_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fr_in = 1'b0;
    logic fv_in = 1'b0;
    logic standby = 1'b0;
    logic ld_en = 1'b1;
    logic up, dn, cp_hiz, ld;
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    pfd_lockdet u_pfd_lockdet (
        .clk(clk), .rst(rst), .fr_in(fr_in), .fv_in(fv_in),
        .standby(standby), .ld_en(ld_en),
        .up(up), .dn(dn), .cp_hiz(cp_hiz), .ld(ld)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    // drive at the falling edge, then sample 1 ns after the next rising edge
    task automatic step(input logic a, input logic b);
        @(negedge clk);
        fr_in = a;
        fv_in = b;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; standby = 1'b0; ld_en = 1'b1; fr_in = 1'b0; fv_in = 1'b0;
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // one comparison: first edge at cycle 0, partner `gap` cycles later
    task automatic frame(input int gap, input bit ref_first);
        int ifr = ref_first ? 0 : gap;
        int ifv = ref_first ? gap : 0;
        for (int k = 0; k < 10; k++) step(k == ifr, k == ifv);
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        chk("R4 reset up", up, 1'b0);
        chk("R4 reset dn", dn, 1'b0);
        chk("R4 reset hiz", cp_hiz, 1'b1);
        chk("R6 reset ld", ld, 1'b0);
    endtask

    task automatic t_up_then_down();
        do_reset();
        step(1'b1, 1'b0);
        chk("R1 up set", up, 1'b1);
        chk("R1 dn idle", dn, 1'b0);
        chk("R4 hiz off", cp_hiz, 1'b0);
        step(1'b0, 1'b0);
        step(1'b0, 1'b0);
        chk("R1 up held", up, 1'b1);
        step(1'b0, 1'b1);
        chk("R3 overlap up", up, 1'b1);
        chk("R3 overlap dn", dn, 1'b1);
        step(1'b1, 1'b0);          // edge during overlap is ignored
        chk("R3 clear up", up, 1'b0);
        chk("R3 clear dn", dn, 1'b0);
        chk("R4 hiz back", cp_hiz, 1'b1);
        step(1'b0, 1'b0);
        chk("R3 ignored edge up", up, 1'b0);
    endtask

    task automatic t_down_first();
        do_reset();
        step(1'b0, 1'b1);
        chk("R2 dn set", dn, 1'b1);
        chk("R2 up idle", up, 1'b0);
        step(1'b0, 1'b0);
        chk("R2 dn held", dn, 1'b1);
        step(1'b1, 1'b0);
        step(1'b0, 1'b0);
        chk("R2 dn cleared", dn, 1'b0);
    endtask

    task automatic t_lock_run();
        do_reset();
        frame(1, 1'b1);
        frame(0, 1'b1);
        frame(1, 1'b0);
        chk("R6 three runs no lock", ld, 1'b0);
        frame(1, 1'b1);
        chk("R6 fourth run locks", ld, 1'b1);
        frame(0, 1'b0);
        chk("R6 lock kept", ld, 1'b1);
    endtask

    task automatic t_window_edge();
        do_reset();
        for (int i = 0; i < 5; i++) frame(2, 1'b1);
        chk("R5 gap two never locks", ld, 1'b0);
        do_reset();
        frame(1, 1'b1); frame(1, 1'b1); frame(1, 1'b1);
        frame(2, 1'b0);
        frame(1, 1'b1); frame(1, 1'b1); frame(1, 1'b1);
        chk("R7 run restarts", ld, 1'b0);
        frame(1, 1'b0);
        chk("R5 gap one counts", ld, 1'b1);
    endtask

    task automatic t_early_drop();
        do_reset();
        for (int i = 0; i < 4; i++) frame(0, 1'b1);
        chk("R6 locked before miss", ld, 1'b1);
        step(1'b1, 1'b0);
        chk("R7 one cycle pending", ld, 1'b1);
        step(1'b0, 1'b0);
        chk("R7 still inside", ld, 1'b1);
        step(1'b0, 1'b0);
        chk("R7 drop at window", ld, 1'b0);
        for (int k = 0; k < 4; k++) step(1'b0, 1'b0);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R7 stays low", ld, 1'b0);
    endtask

    task automatic t_standby();
        do_reset();
        for (int i = 0; i < 4; i++) frame(1, 1'b1);
        step(1'b1, 1'b0);
        @(negedge clk);
        standby = 1'b1;
        #1;
        chk("R8 ld high", ld, 1'b1);
        chk("R8 up off", up, 1'b0);
        chk("R8 hiz", cp_hiz, 1'b1);
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        chk("R8 dn off", dn, 1'b0);
        chk("R8 ld still high", ld, 1'b1);
        @(negedge clk);
        standby = 1'b0;
        #1;
        chk("R8 exit ld low", ld, 1'b0);
        chk("R8 exit hiz", cp_hiz, 1'b1);
        frame(1, 1'b1); frame(1, 1'b1); frame(1, 1'b1);
        chk("R8 run restarted", ld, 1'b0);
    endtask

    task automatic t_ld_enable();
        do_reset();
        for (int i = 0; i < 4; i++) frame(1, 1'b0);
        @(negedge clk);
        ld_en = 1'b0;
        #1;
        chk("R9 disabled low", ld, 1'b0);
        frame(1, 1'b1);
        chk("R9 disabled still low", ld, 1'b0);
        @(negedge clk);
        ld_en = 1'b1;
        #1;
        chk("R9 reenabled high", ld, 1'b1);
    endtask

    task automatic t_held_pulse();
        do_reset();
        step(1'b1, 1'b0);
        for (int k = 0; k < 6; k++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b1);
        chk("R3 held inputs clear up", up, 1'b0);
        step(1'b1, 1'b1);
        chk("R1 no retrigger while held", up, 1'b0);
        chk("R4 hiz while held", cp_hiz, 1'b1);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_up_then_down();
        t_down_first();
        t_lock_run();
        t_window_edge();
        t_early_drop();
        t_standby();
        t_ld_enable();
        t_held_pulse();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule